// File: doc/BRIEF.md
# Key Matrix Scanner with Serial Readout

The block scans a key matrix of six drive lines by five sense lines. Each drive line goes high in turn. The five sense inputs are sampled while that line is high, which builds a 30-bit raw frame. A frame is accepted only after it has been seen unchanged over consecutive frames. When the accepted image differs from the stored one, the block stores it, together with a flag that records whether the press woke the block from sleep. It then pulls the serial data-out line low to tell the host that fresh data is waiting.

The host reads the data over a three-wire serial link with an enable line. First it clocks in an 8-bit device address while enable is low. Then it raises enable and clocks out 31 bits: the 30 key bits, followed by the wake flag. One control input hands the first two drive lines over to segment use. While it is set, those lines stay low and their ten key bits read as zero.

A sleep request parks the scanner with every usable drive line high. The first key that pulls a sense input high restarts scanning. Withdrawing the request also restarts scanning.

Top module: `keymat_reader`

## Requirements
- R1: After reset, `ser_dout_o` is 1, `scan_active_o` is 1 and `scan_o` is 6'b000001.
- R2: While active, `scan_o` has at most one bit set. The set bit steps from bit 0 up to bit 5 and wraps back to bit 0, holding on each line for SCAN_DIV (4) clock cycles.
- R3: A closed contact between drive line r and sense input c (both counted from 0) sets bit r*5+c of the key image. All other bits are 0.
- R4: While `row_share_i` is 1, `scan_o[1:0]` stays 0 and key image bits 0 to 9 read 0.
- R5: A new image is stored only after the same frame has been seen in DEB_FRAMES (2) consecutive full frames, and only if it differs from the stored one. This covers both presses and releases. Storing an image drives `ser_dout_o` to 0 while no read is in progress. A press shorter than one frame is never stored.
- R6: Sleep is entered at a frame end when either bit of `sleep_req_i` is 1 and both the stored image and the current frame are empty. While asleep, `scan_active_o` is 0, `scan_o[5:2]` are 1, `scan_o[1:0]` equal the inverse of `row_share_i`, and no image is stored. A held key keeps the block awake.
- R7: While asleep, any sense input at 1, or both request bits at 0, returns the block to scanning within 4 clock cycles. After waking it stays awake for at least DEB_FRAMES+2 frames.
- R8: The last bit read, bit 30 (the wake flag), is 1 for an image stored after a key wake-up. It is 0 otherwise, including the later release image.
- R9: Address bits are taken least significant bit first, on rising serial clock edges while enable is low. Only the address 0x43 opens a read. Any other address leaves `ser_dout_o` showing the data-waiting status and keeps the waiting data.
- R10: At the rise of enable, `ser_dout_o` shows key bit 0. Each rising serial clock edge advances by one bit: key bits 0 to 29, then the wake flag. Bits beyond these read 0.
- R11: A read completes when enable falls after at least 30 rising edges. Completion returns `ser_dout_o` to 1, whether the serial clock was left low or high. A read ended earlier leaves the data waiting.
- R12: A read opened while `ser_dout_o` is 1 shifts out 31 zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| row_share_i | input | 1 | Hands drive lines 0 and 1 over to segment use |
| sleep_req_i | input | 2 | Sleep request; either bit set requests sleep |
| sense_i | input | 5 | Sense inputs from the matrix, high when a key closes |
| scan_o | output | 6 | Drive lines, active high |
| scan_active_o | output | 1 | 1 while scanning, 0 while asleep |
| ser_en_i | input | 1 | Serial enable: low for the address, high for the read |
| ser_clk_i | input | 1 | Serial clock |
| ser_din_i | input | 1 | Serial address input |
| ser_dout_o | output | 1 | Serial data; low when fresh data is waiting |

## Verification
Every one of the 30 keys is pressed alone and read back. Reads alternate between ending with the clock low and ending with it high. An error in the line-and-column arithmetic shows up as a shifted bit, and a completion that depends on the final clock edge leaves the data-out line stuck low. Further tests cover segment sharing with all keys held, a press shorter than a frame, a wrong address, an aborted read and a read opened with nothing waiting. A design that stored a bounce, dropped data on a foreign address or replayed stale bits would show a wrong word or a wrong data-out level. Sleep tests use both request bits, a held key, a wake by key and a wake by withdrawing the request. They catch a wake flag that is never set or is set on the wrong image.

// File: rtl/kmr_pkg.sv
package kmr_pkg;

  // serial port session state
  typedef enum logic [1:0] {
    SS_IDLE = 2'd0,
    SS_SKIP = 2'd1,
    SS_SEND = 2'd2
  } ser_state_e;

  // width for a counter that must hold values 0..n
  function automatic int cnt_width(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/kmr_sync.sv
module kmr_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end

endmodule

// File: rtl/kmr_scan.sv
module kmr_scan #(
  parameter int ROWS        = 6,
  parameter int COLS        = 5,
  parameter int SCAN_DIV    = 4,
  parameter int DEB_FRAMES  = 2,
  parameter int SHARED_ROWS = 2,
  parameter int HOLD_FRAMES = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [COLS-1:0]      sense_s,
  input  logic                 share_i,
  input  logic                 sleep_req,
  output logic [ROWS-1:0]      scan_o,
  output logic                 active_o,
  output logic [ROWS*COLS-1:0] image_o,
  output logic                 sa_o,
  output logic                 latch_o
);
  import kmr_pkg::*;

  localparam int KEYS = ROWS * COLS;
  localparam int RW   = cnt_width(ROWS - 1);
  localparam int DW   = cnt_width(SCAN_DIV - 1);
  localparam int SW   = cnt_width(DEB_FRAMES);
  localparam int FW   = cnt_width(HOLD_FRAMES);

  logic [RW-1:0]   row_idx;
  logic [ROWS-1:0] row_oh;
  logic [DW-1:0]   div_cnt;
  logic [KEYS-1:0] frame_raw, frame_full, prev_frame, image_q, key_mask;
  logic [ROWS-1:0] row_en;
  logic [COLS-1:0] row_sample;
  logic [SW-1:0]   stable_cnt;
  logic [FW-1:0]   hold_cnt;
  logic            sleeping, woke, sa_q, latch_q;
  logic            row_end, frame_end, stable_hit, deb_ok, do_latch, go_sleep, wake;

  // lines handed to segment use are neither driven nor read
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    if (r < SHARED_ROWS) begin : g_shared
      assign row_en[r]                 = ~share_i;
      assign key_mask[r*COLS +: COLS]  = {COLS{~share_i}};
    end else begin : g_plain
      assign row_en[r]                 = 1'b1;
      assign key_mask[r*COLS +: COLS]  = {COLS{1'b1}};
    end
  end

  assign row_sample = sense_s & {COLS{row_en[row_idx]}};

  always_comb begin
    frame_full = frame_raw;
    frame_full[row_idx*COLS +: COLS] = row_sample;
  end

  assign row_end    = (div_cnt == DW'(SCAN_DIV - 1));
  assign frame_end  = row_end && (row_idx == RW'(ROWS - 1));
  assign stable_hit = (frame_full == prev_frame);
  assign deb_ok     = stable_hit && ((int'(stable_cnt) + 2) >= DEB_FRAMES);
  assign do_latch   = frame_end && deb_ok && (frame_full != image_q);
  assign go_sleep   = frame_end && !do_latch && sleep_req && (hold_cnt == '0)
                      && (image_q == '0) && (frame_full == '0);
  assign wake       = sleeping && ((|sense_s) || !sleep_req);

  always_ff @(posedge clk) begin
    if (rst) begin
      row_idx    <= '0;
      row_oh     <= ROWS'(1);
      div_cnt    <= '0;
      frame_raw  <= '0;
      prev_frame <= '0;
      image_q    <= '0;
      stable_cnt <= '0;
      hold_cnt   <= '0;
      sleeping   <= 1'b0;
      woke       <= 1'b0;
      sa_q       <= 1'b0;
      latch_q    <= 1'b0;
    end else begin
      latch_q <= 1'b0;
      if (sleeping) begin
        if (wake) begin
          sleeping   <= 1'b0;
          woke       <= |sense_s;
          hold_cnt   <= FW'(HOLD_FRAMES);
          row_idx    <= '0;
          row_oh     <= ROWS'(1);
          div_cnt    <= '0;
          stable_cnt <= '0;
        end
      end else if (row_end) begin
        div_cnt   <= '0;
        frame_raw <= frame_full;
        if (row_idx == RW'(ROWS - 1)) begin
          row_idx <= '0;
          row_oh  <= ROWS'(1);
        end else begin
          row_idx <= row_idx + RW'(1);
          row_oh  <= row_oh << 1;
        end
        if (frame_end) begin
          prev_frame <= frame_full;
          if (!stable_hit)
            stable_cnt <= '0;
          else if (stable_cnt != SW'(DEB_FRAMES))
            stable_cnt <= stable_cnt + SW'(1);
          if (hold_cnt != '0)
            hold_cnt <= hold_cnt - FW'(1);
          if (do_latch) begin
            image_q <= frame_full;
            sa_q    <= woke;
            woke    <= 1'b0;
            latch_q <= 1'b1;
          end
          if (go_sleep)
            sleeping <= 1'b1;
        end
      end else begin
        div_cnt <= div_cnt + DW'(1);
      end
    end
  end

  assign scan_o   = sleeping ? row_en : (row_oh & row_en);
  assign active_o = ~sleeping;
  assign image_o  = image_q & key_mask;
  assign sa_o     = sa_q;
  assign latch_o  = latch_q;

endmodule

// File: rtl/kmr_serial.sv
module kmr_serial #(
  parameter int          NB       = 31,
  parameter int          AW       = 8,
  parameter logic [7:0]  DEV_ADDR = 8'h43
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en_s,
  input  logic          sclk_s,
  input  logic          din_s,
  input  logic [NB-1:0] word_i,
  input  logic          latch_i,
  output logic          dout_o
);
  import kmr_pkg::*;

  localparam int CW = cnt_width(NB - 1);

  logic          sclk_d, en_d, sclk_rise, en_rise, en_fall, done;
  logic [AW-1:0] addr_sr;
  ser_state_e    state;
  logic [NB-1:0] snap;
  logic [CW-1:0] bit_cnt;
  logic          pending, dout_q;

  assign sclk_rise = sclk_s & ~sclk_d;
  assign en_rise   = en_s & ~en_d;
  assign en_fall   = ~en_s & en_d;
  assign done      = en_fall && (state == SS_SEND) && (bit_cnt == CW'(NB - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d  <= 1'b0;
      en_d    <= 1'b0;
      addr_sr <= '0;
      state   <= SS_IDLE;
      snap    <= '0;
      bit_cnt <= '0;
      pending <= 1'b0;
      dout_q  <= 1'b1;
    end else begin
      sclk_d <= sclk_s;
      en_d   <= en_s;
      if (!en_s && sclk_rise)
        addr_sr <= {din_s, addr_sr[AW-1:1]};

      if (en_rise) begin
        bit_cnt <= '0;
        if (addr_sr == AW'(DEV_ADDR)) begin
          state <= SS_SEND;
          snap  <= pending ? word_i : '0;
        end else begin
          state <= SS_SKIP;
        end
      end else if (en_fall) begin
        state <= SS_IDLE;
      end else if ((state == SS_SEND) && sclk_rise) begin
        snap <= snap >> 1;
        if (bit_cnt != CW'(NB - 1))
          bit_cnt <= bit_cnt + CW'(1);
      end

      if (latch_i)
        pending <= 1'b1;
      else if (done)
        pending <= 1'b0;

      dout_q <= (state == SS_SEND) ? snap[0] : ~pending;
    end
  end

  assign dout_o = dout_q;

endmodule

// File: rtl/keymat_reader.sv
module keymat_reader #(
  parameter int         ROWS        = 6,
  parameter int         COLS        = 5,
  parameter int         SCAN_DIV    = 4,
  parameter int         DEB_FRAMES  = 2,
  parameter int         SHARED_ROWS = 2,
  parameter logic [7:0] DEV_ADDR    = 8'h43
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            row_share_i,
  input  logic [1:0]      sleep_req_i,
  input  logic [COLS-1:0] sense_i,
  output logic [ROWS-1:0] scan_o,
  output logic            scan_active_o,
  input  logic            ser_en_i,
  input  logic            ser_clk_i,
  input  logic            ser_din_i,
  output logic            ser_dout_o
);

  localparam int KEYS = ROWS * COLS;
  localparam int NB   = KEYS + 1;

  logic [COLS-1:0] sense_s;
  logic [2:0]      ser_s;
  logic [KEYS-1:0] key_image;
  logic            key_sa, key_latch;

  kmr_sync #(.W(COLS)) u_sense_sync (
    .clk(clk), .rst(rst), .d(sense_i), .q(sense_s)
  );

  kmr_sync #(.W(3)) u_ser_sync (
    .clk(clk), .rst(rst), .d({ser_din_i, ser_clk_i, ser_en_i}), .q(ser_s)
  );

  kmr_scan #(
    .ROWS(ROWS), .COLS(COLS), .SCAN_DIV(SCAN_DIV), .DEB_FRAMES(DEB_FRAMES),
    .SHARED_ROWS(SHARED_ROWS), .HOLD_FRAMES(DEB_FRAMES + 2)
  ) u_scan (
    .clk(clk), .rst(rst), .sense_s(sense_s), .share_i(row_share_i),
    .sleep_req(|sleep_req_i), .scan_o(scan_o), .active_o(scan_active_o),
    .image_o(key_image), .sa_o(key_sa), .latch_o(key_latch)
  );

  kmr_serial #(.NB(NB), .AW(8), .DEV_ADDR(DEV_ADDR)) u_serial (
    .clk(clk), .rst(rst), .en_s(ser_s[0]), .sclk_s(ser_s[1]), .din_s(ser_s[2]),
    .word_i({key_sa, key_image}), .latch_i(key_latch), .dout_o(ser_dout_o)
  );

endmodule

// File: rtl/kmr_checker.sv
module kmr_checker #(
  parameter int ROWS        = 6,
  parameter int COLS        = 5,
  parameter int SHARED_ROWS = 2
) (
  input logic            clk,
  input logic            rst,
  input logic [ROWS-1:0] scan_o,
  input logic            active,
  input logic            share,
  input logic [COLS-1:0] sense_s,
  input logic            latch
);

  AST_ROW_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    active |-> $onehot0(scan_o)); // R2

  AST_SHARED_ROWS_LOW: assert property (@(posedge clk) disable iff (rst)
    share |-> (scan_o[SHARED_ROWS-1:0] == '0)); // R4

  AST_SLEEP_ROWS_HIGH: assert property (@(posedge clk) disable iff (rst)
    !active |-> (&scan_o[ROWS-1:SHARED_ROWS])); // R6

  AST_SLEEP_NO_LATCH: assert property (@(posedge clk) disable iff (rst)
    !active |-> !latch); // R6

  AST_WAKE_ON_SENSE: assert property (@(posedge clk) disable iff (rst)
    (!active && (|sense_s)) |=> active); // R7

endmodule

bind keymat_reader kmr_checker #(
  .ROWS(ROWS), .COLS(COLS), .SHARED_ROWS(SHARED_ROWS)
) u_chk (
  .clk(clk), .rst(rst), .scan_o(scan_o), .active(scan_active_o),
  .share(row_share_i), .sense_s(sense_s), .latch(key_latch)
);

// File: tb/sim_keymat_reader.sv
module sim_keymat_reader;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;
  localparam int SETTLE     = 300;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        row_share_i = 1'b0;
  logic [1:0]  sleep_req_i = 2'b00;
  logic [4:0]  sense_i;
  logic [5:0]  scan_o;
  logic        scan_active_o;
  logic        ser_en_i = 1'b0, ser_clk_i = 1'b0, ser_din_i = 1'b0;
  logic        ser_dout_o;
  logic [29:0] pressed = '0;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  keymat_reader u0 (
    .clk(clk), .rst(rst), .row_share_i(row_share_i), .sleep_req_i(sleep_req_i),
    .sense_i(sense_i), .scan_o(scan_o), .scan_active_o(scan_active_o),
    .ser_en_i(ser_en_i), .ser_clk_i(ser_clk_i), .ser_din_i(ser_din_i),
    .ser_dout_o(ser_dout_o)
  );

  // matrix model: a closed key joins its drive line to its sense input
  always_comb begin
    for (int c = 0; c < 5; c++) begin
      sense_i[c] = 1'b0;
      for (int r = 0; r < 6; r++)
        sense_i[c] = sense_i[c] | (scan_o[r] & pressed[r*5 + c]);
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ser_read(input logic [7:0] addr, input int nedges,
                          input bit idle_high, output logic [30:0] bits);
    bits = '0;
    ser_en_i = 1'b0;
    for (int i = 0; i < 8; i++) begin
      ser_din_i = addr[i];
      ser_clk_i = 1'b0; wait_cyc(HALF);
      ser_clk_i = 1'b1; wait_cyc(HALF);
    end
    if (!idle_high) begin ser_clk_i = 1'b0; wait_cyc(HALF); end
    ser_en_i = 1'b1; wait_cyc(HALF);
    bits[0] = ser_dout_o;
    for (int k = 1; k <= nedges; k++) begin
      ser_clk_i = 1'b0; wait_cyc(HALF);
      ser_clk_i = 1'b1; wait_cyc(HALF);
      if (k < 31) bits[k] = ser_dout_o;
    end
    if (!idle_high) begin ser_clk_i = 1'b0; wait_cyc(HALF); end
    ser_en_i = 1'b0; wait_cyc(HALF);
  endtask

  function automatic logic [29:0] keep_mask(input bit share);
    return share ? {20'hFFFFF, 10'h000} : 30'h3FFFFFFF;
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [30:0] rd;
    logic [30:0] exp;
    logic [5:0]  prev;
    int          r0;
    int          bad;

    wait_cyc(4);
    rst = 1'b0;
    wait_cyc(1);
    // R1 reset state
    chk(ser_dout_o == 1'b1, "R1 dout", ser_dout_o, 1);
    chk(scan_active_o == 1'b1, "R1 active", scan_active_o, 1);
    chk(scan_o == 6'b000001, "R1 scan", scan_o, 6'b000001);

    // R2 drive line order and dwell
    prev = scan_o;
    while (scan_o == prev) wait_cyc(1);
    r0 = 0;
    for (int r = 0; r < 6; r++) if (scan_o[r]) r0 = r;
    bad = 0;
    for (int i = 0; i < 48; i++) begin
      if (scan_o != 6'(1 << ((r0 + i/4) % 6))) bad++;
      wait_cyc(1);
    end
    chk(bad == 0, "R2 sequence", bad, 0);

    // R3 R5 R10 R11 sweep every key alone
    for (int k = 0; k < 30; k++) begin
      pressed = 30'(1) << k;
      wait_cyc(SETTLE);
      chk(ser_dout_o == 1'b0, "R5 stored press", ser_dout_o, 0);
      ser_read(8'h43, 30, k[0], rd);
      exp = {1'b0, 30'(1) << k};
      chk(rd == exp, "R3 R10 single key", rd, exp);
      chk(ser_dout_o == 1'b1, "R11 complete", ser_dout_o, 1);
      pressed = '0;
      wait_cyc(SETTLE);
      ser_read(8'h43, 30, !k[0], rd);
      chk(rd == '0, "R5 release image", rd, 0);
    end

    // R12 read with nothing waiting
    ser_read(8'h43, 30, 1'b0, rd);
    chk(rd == '0, "R12 stale read", rd, 0);

    // R5 a press shorter than a frame is never stored
    pressed = 30'(1) << 12;
    wait_cyc(10);
    pressed = '0;
    wait_cyc(SETTLE);
    chk(ser_dout_o == 1'b1, "R5 short press", ser_dout_o, 1);
    // R5 no early store
    pressed = 30'(1) << 8;
    wait_cyc(20);
    chk(ser_dout_o == 1'b1, "R5 early", ser_dout_o, 1);
    wait_cyc(SETTLE);
    ser_read(8'h43, 30, 1'b0, rd);
    chk(rd == {1'b0, 30'(1) << 8}, "R5 after debounce", rd, {1'b0, 30'(1) << 8});

    // multi-key patterns, R3
    pressed = 30'h2AAAAAAA;
    wait_cyc(SETTLE);
    ser_read(8'h43, 30, 1'b1, rd);
    chk(rd == {1'b0, 30'h2AAAAAAA}, "R3 pattern A", rd, {1'b0, 30'h2AAAAAAA});
    pressed = 30'h3FFFFFFF;
    wait_cyc(SETTLE);
    ser_read(8'h43, 30, 1'b0, rd);
    chk(rd == {1'b0, 30'h3FFFFFFF}, "R3 all keys", rd, {1'b0, 30'h3FFFFFFF});

    // R4 shared lines
    row_share_i = 1'b1;
    wait_cyc(SETTLE);
    chk(scan_o[1:0] == 2'b00, "R4 lines low", scan_o, 0);
    ser_read(8'h43, 30, 1'b1, rd);
    exp = {1'b0, 30'h3FFFFFFF & keep_mask(1'b1)};
    chk(rd == exp, "R4 masked image", rd, exp);
    pressed = '0;
    wait_cyc(SETTLE);
    row_share_i = 1'b0;
    ser_read(8'h43, 30, 1'b0, rd);

    // R9 wrong address, R11 abort
    pressed = 30'(1) << 3;
    wait_cyc(SETTLE);
    ser_read(8'h42, 30, 1'b0, rd);
    chk(rd == '0, "R9 foreign addr shows waiting", rd, 0);
    chk(ser_dout_o == 1'b0, "R9 data kept", ser_dout_o, 0);
    ser_read(8'h43, 10, 1'b0, rd);
    chk(rd[10:0] == 11'b00000001000, "R10 partial bits", rd[10:0], 11'b00000001000);
    chk(ser_dout_o == 1'b0, "R11 abort keeps data", ser_dout_o, 0);
    ser_read(8'h43, 34, 1'b1, rd);
    chk(rd == {1'b0, 30'(1) << 3}, "R10 full after abort", rd, {1'b0, 30'(1) << 3});
    chk(ser_dout_o == 1'b1, "R11 idle high done", ser_dout_o, 1);

    // R6 held key keeps block awake
    sleep_req_i = 2'b01;
    wait_cyc(SETTLE);
    chk(scan_active_o == 1'b1, "R6 held key awake", scan_active_o, 1);
    pressed = '0;
    wait_cyc(SETTLE);
    chk(scan_active_o == 1'b0, "R6 asleep", scan_active_o, 0);
    chk(scan_o == 6'b111111, "R6 lines high", scan_o, 6'b111111);
    ser_read(8'h43, 30, 1'b0, rd);
    chk(rd == '0, "R8 release flag", rd, 0);

    // R7 R8 wake by key
    pressed = 30'(1) << 17;
    wait_cyc(6);
    chk(scan_active_o == 1'b1, "R7 woke", scan_active_o, 1);
    wait_cyc(SETTLE);
    ser_read(8'h43, 30, 1'b1, rd);
    exp = {1'b1, 30'(1) << 17};
    chk(rd == exp, "R8 wake flag", rd, exp);
    pressed = '0;
    wait_cyc(SETTLE);
    ser_read(8'h43, 30, 1'b0, rd);
    chk(rd == '0, "R8 release after wake", rd, 0);
    wait_cyc(SETTLE);
    chk(scan_active_o == 1'b0, "R6 back asleep", scan_active_o, 0);

    // R7 wake by withdrawing the request, then other request bit
    sleep_req_i = 2'b00;
    wait_cyc(6);
    chk(scan_active_o == 1'b1, "R7 request withdrawn", scan_active_o, 1);
    sleep_req_i = 2'b10;
    wait_cyc(SETTLE);
    chk(scan_active_o == 1'b0, "R6 second request bit", scan_active_o, 0);
    pressed = 30'(1) << 29;
    wait_cyc(SETTLE);
    ser_read(8'h43, 30, 1'b0, rd);
    exp = {1'b1, 30'(1) << 29};
    chk(rd == exp, "R8 wake flag last key", rd, exp);
    pressed = '0;
    sleep_req_i = 2'b00;
    wait_cyc(SETTLE);
    ser_read(8'h43, 30, 1'b1, rd);
    chk(rd == '0, "R8 flag cleared", rd, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule